// File: doc/BRIEF.md
# First-Error ECC Log Capture

This block keeps a record of the first memory ECC error seen after software has cleared the error flags. Each cycle an ECC decoder may report, for each of the four 64-bit quadwords of a burst, a correctable indication, an uncorrectable indication and an 8-bit syndrome. Alongside these come the rank, bank, row and column of the burst.

When no flag is set and the burst carries at least one error, the block picks one quadword by a fixed priority and packs its syndrome, error type, quadword index and address into a 64-bit read-only log word. It then raises the matching flags. After that the log is frozen. Later errors can still raise a flag, but they do not touch the log until software has dropped every flag with the per-flag clear inputs.

Top module: `ecc_first_err_log`

## Requirements
- R1: After reset the log word is all zeros and both flags are low.
- R2: When both flags are low and a burst reports any error, the log word at the next clock edge holds that burst's selected error.
- R3: While either flag is set and not cleared in that cycle, the log word does not change, whatever errors arrive.
- R4: A pulse on clr_ce drops the correctable flag, and a pulse on clr_ue drops the uncorrectable flag, at the next edge. The log word keeps its contents.
- R5: Among errors in one burst, the logged one is the uncorrectable error with the lowest quadword index if any exists. Otherwise it is the correctable error with the lowest quadword index.
- R6: Log layout: [63:56] syndrome of the selected quadword, [55] 1 for uncorrectable and 0 for correctable, [54:53] quadword index, [52:51] rank, [50:48] bank, [47:32] row, [31:20] column, [19:0] zero.
- R7: Flags update at the same edge as the capture. The correctable flag is set if any quadword reports a correctable error, and the uncorrectable flag is set if any quadword reports an uncorrectable error.
- R8: When a clear and a new error of the same type arrive in the same cycle, the flag ends up set. If no other flag remains set, the new error is captured.
- R9: An uncorrectable error that arrives while only the correctable flag is set raises the uncorrectable flag, and the log word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_vld | input | 4 | Correctable error per quadword, bit i is quadword i |
| ue_vld | input | 4 | Uncorrectable error per quadword, bit i is quadword i |
| syn_in | input | 32 | Syndromes, quadword i in bits [8i+7:8i] |
| rank_in | input | 2 | Rank of the burst |
| bank_in | input | 3 | Bank of the burst |
| row_in | input | 16 | Row of the burst |
| col_in | input | 12 | Column of the burst |
| clr_ce | input | 1 | Software clear of the correctable flag |
| clr_ue | input | 1 | Software clear of the uncorrectable flag |
| log_q | output | 64 | Captured error log word |
| ce_flag | output | 1 | Correctable error flag |
| ue_flag | output | 1 | Uncorrectable error flag |

## Verification
The bench aims at bursts that mix both error types across quadwords. A design with the wrong priority would log a correctable or higher-index quadword while an uncorrectable lower-index one was present. It also drives clears in the same cycle as new errors. A design that gave precedence to the clear would lose the flag or miss the capture. Correctable-flagged states that then receive an uncorrectable error expose a design that re-captures or fails to raise the second flag. Long random runs with sparse clears check that nothing leaks into the log while it is locked.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int QW_N   = 4;
    localparam int SYN_W  = 8;
    localparam int RANK_W = 2;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 16;
    localparam int COL_W  = 12;
    localparam int LOG_W  = 64;
    localparam int QIDX_W = $clog2(QW_N);

    typedef struct packed {
        logic             ce;
        logic             ue;
        logic [LOG_W-1:0] log;
    } log_state_t;
endpackage

// File: rtl/ecc_err_prio.sv
module ecc_err_prio #(
    parameter int QW_N   = 4,
    parameter int SYN_W  = 8,
    localparam int QIDX_W = $clog2(QW_N)
) (
    input  logic [QW_N-1:0]       ce_vld,
    input  logic [QW_N-1:0]       ue_vld,
    input  logic [QW_N*SYN_W-1:0] syn_in,
    output logic                  hit,
    output logic                  sel_ue,
    output logic [QIDX_W-1:0]     sel_idx,
    output logic [SYN_W-1:0]      sel_syn
);
    localparam int REQ_N = 2 * QW_N;

    logic [REQ_N-1:0] req;
    logic [REQ_N-1:0] grant;
    logic [QW_N-1:0]  qw_pick;

    // Lower request index means higher priority: uncorrectable first.
    assign req   = {ce_vld, ue_vld};
    assign grant = req & (~req + REQ_N'(1));
    assign hit   = |req;
    assign sel_ue = |grant[QW_N-1:0];

    generate
        for (genvar q = 0; q < QW_N; q++) begin : g_pick
            assign qw_pick[q] = grant[q] | grant[q+QW_N];
        end
    endgenerate

    always_comb begin
        sel_idx = '0;
        sel_syn = '0;
        for (int q = 0; q < QW_N; q++) begin
            if (qw_pick[q]) begin
                sel_idx = QIDX_W'(q);
                sel_syn = syn_in[q*SYN_W +: SYN_W];
            end
        end
    end
endmodule

// File: rtl/ecc_log_pack.sv
module ecc_log_pack #(
    parameter int SYN_W  = 8,
    parameter int QIDX_W = 2,
    parameter int RANK_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int COL_W  = 12,
    parameter int LOG_W  = 64
) (
    input  logic              sel_ue,
    input  logic [QIDX_W-1:0] sel_idx,
    input  logic [SYN_W-1:0]  sel_syn,
    input  logic [RANK_W-1:0] rank_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    output logic [LOG_W-1:0]  word
);
    localparam int SYN_LSB  = LOG_W - SYN_W;
    localparam int TYPE_BIT = SYN_LSB - 1;
    localparam int QIDX_LSB = TYPE_BIT - QIDX_W;
    localparam int RANK_LSB = QIDX_LSB - RANK_W;
    localparam int BANK_LSB = RANK_LSB - BANK_W;
    localparam int ROW_LSB  = BANK_LSB - ROW_W;
    localparam int COL_LSB  = ROW_LSB - COL_W;

    always_comb begin
        word = '0;
        word[SYN_LSB  +: SYN_W]  = sel_syn;
        word[TYPE_BIT]           = sel_ue;
        word[QIDX_LSB +: QIDX_W] = sel_idx;
        word[RANK_LSB +: RANK_W] = rank_in;
        word[BANK_LSB +: BANK_W] = bank_in;
        word[ROW_LSB  +: ROW_W]  = row_in;
        word[COL_LSB  +: COL_W]  = col_in;
    end
endmodule

// File: rtl/ecc_first_err_log.sv
module ecc_first_err_log
    import ecc_log_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [QW_N-1:0]       ce_vld,
    input  logic [QW_N-1:0]       ue_vld,
    input  logic [QW_N*SYN_W-1:0] syn_in,
    input  logic [RANK_W-1:0]     rank_in,
    input  logic [BANK_W-1:0]     bank_in,
    input  logic [ROW_W-1:0]      row_in,
    input  logic [COL_W-1:0]      col_in,
    input  logic                  clr_ce,
    input  logic                  clr_ue,
    output logic [LOG_W-1:0]      log_q,
    output logic                  ce_flag,
    output logic                  ue_flag
);
    log_state_t        st_d, st_q;
    logic              hit, sel_ue;
    logic [QIDX_W-1:0] sel_idx;
    logic [SYN_W-1:0]  sel_syn;
    logic [LOG_W-1:0]  new_word;
    logic              ce_hold, ue_hold;

    ecc_err_prio #(.QW_N(QW_N), .SYN_W(SYN_W)) i_prio (
        .ce_vld (ce_vld),
        .ue_vld (ue_vld),
        .syn_in (syn_in),
        .hit    (hit),
        .sel_ue (sel_ue),
        .sel_idx(sel_idx),
        .sel_syn(sel_syn)
    );

    ecc_log_pack #(
        .SYN_W(SYN_W), .QIDX_W(QIDX_W), .RANK_W(RANK_W), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .COL_W(COL_W), .LOG_W(LOG_W)
    ) i_pack (
        .sel_ue (sel_ue),
        .sel_idx(sel_idx),
        .sel_syn(sel_syn),
        .rank_in(rank_in),
        .bank_in(bank_in),
        .row_in (row_in),
        .col_in (col_in),
        .word   (new_word)
    );

    always_comb begin
        st_d    = st_q;
        ce_hold = st_q.ce & ~clr_ce;
        ue_hold = st_q.ue & ~clr_ue;
        // A new error beats a clear of the same flag.
        st_d.ce = ce_hold | (|ce_vld);
        st_d.ue = ue_hold | (|ue_vld);
        if (hit && !(ce_hold || ue_hold)) begin
            st_d.log = new_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign log_q   = st_q.log;
    assign ce_flag = st_q.ce;
    assign ue_flag = st_q.ue;

    assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ce_flag && !clr_ce) || (ue_flag && !clr_ue)) |=> $stable(log_q));

    assert_ue_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ue_vld) |=> ue_flag);

    assert_ce_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ce && (|ce_vld)) |=> ce_flag);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ue && !(|ue_vld)) |=> !ue_flag);

    assert_upgrade_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_flag && !clr_ce && !ue_flag && (|ue_vld)) |=> (ue_flag && $stable(log_q)));
endmodule

// File: tb/test_ecc_first_err_log.sv
module test_ecc_first_err_log;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ce_vld, ue_vld;
    logic [31:0] syn_in;
    logic [1:0]  rank_in;
    logic [2:0]  bank_in;
    logic [15:0] row_in;
    logic [11:0] col_in;
    logic        clr_ce, clr_ue;
    logic [63:0] log_q;
    logic        ce_flag, ue_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] m_log;
    logic        m_ce, m_ue;

    always #5 clk = ~clk;

    ecc_first_err_log i_ecc_first_err_log (
        .clk(clk), .rst_n(rst_n), .ce_vld(ce_vld), .ue_vld(ue_vld),
        .syn_in(syn_in), .rank_in(rank_in), .bank_in(bank_in),
        .row_in(row_in), .col_in(col_in), .clr_ce(clr_ce), .clr_ue(clr_ue),
        .log_q(log_q), .ce_flag(ce_flag), .ue_flag(ue_flag)
    );

    function automatic logic [63:0] exp_word(
        input logic [3:0] ce, input logic [3:0] ue, input logic [31:0] syn,
        input logic [1:0] rk, input logic [2:0] bk, input logic [15:0] rw,
        input logic [11:0] cl);
        int   sel = -1;
        logic t = 1'b0;
        for (int i = 0; i < 4; i++) if (ue[i] && sel < 0) begin sel = i; t = 1'b1; end
        for (int i = 0; i < 4; i++) if (ce[i] && sel < 0) begin sel = i; t = 1'b0; end
        if (sel < 0) return 64'h0;
        return {syn[sel*8 +: 8], t, 2'(sel), rk, bk, rw, cl, 20'h0};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string rl, input string rf);
        chk(rl, log_q, m_log);
        chk(rf, {62'h0, ue_flag, ce_flag}, {62'h0, m_ue, m_ce});
    endtask

    // Drive at negedge, update model, let the edge pass, return at next negedge.
    task automatic step(input logic [3:0] ce, input logic [3:0] ue, input logic [31:0] syn,
                        input logic [1:0] rk, input logic [2:0] bk, input logic [15:0] rw,
                        input logic [11:0] cl, input logic cc, input logic cu);
        logic hc, hu;
        ce_vld = ce; ue_vld = ue; syn_in = syn; rank_in = rk; bank_in = bk;
        row_in = rw; col_in = cl; clr_ce = cc; clr_ue = cu;
        hc = m_ce & ~cc;
        hu = m_ue & ~cu;
        if (((|ce) || (|ue)) && !(hc || hu)) m_log = exp_word(ce, ue, syn, rk, bk, rw, cl);
        m_ce = hc | (|ce);
        m_ue = hu | (|ue);
        @(negedge clk);
    endtask

    task automatic idle();
        step(4'h0, 4'h0, 32'h0, 2'h0, 3'h0, 16'h0, 12'h0, 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 200000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; ce_vld = '0; ue_vld = '0; syn_in = '0; rank_in = '0;
        bank_in = '0; row_in = '0; col_in = '0; clr_ce = 1'b0; clr_ue = 1'b0;
        m_log = '0; m_ce = 1'b0; m_ue = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_all("R1", "R1");

        // R2/R6: single correctable error on quadword 2
        step(4'b0100, 4'b0000, 32'hDDCC_BBAA, 2'd3, 3'd5, 16'hBEEF, 12'hABC, 1'b0, 1'b0);
        w = {8'hCC, 1'b0, 2'd2, 2'd3, 3'd5, 16'hBEEF, 12'hABC, 20'h0};
        chk("R6", log_q, w);
        chk_all("R2", "R7");

        // R3: locked against a later uncorrectable error
        step(4'b0000, 4'b0001, 32'h1111_2222, 2'd0, 3'd1, 16'h0001, 12'h001, 1'b0, 1'b0);
        chk("R3", log_q, w);
        chk_all("R3", "R7");

        // R4: clear only the correctable flag; still locked by ue
        step(4'b0000, 4'b0000, 32'h0, 2'd0, 3'd0, 16'h0, 12'h0, 1'b1, 1'b0);
        chk_all("R4", "R4");
        step(4'b0000, 4'b0000, 32'h0, 2'd0, 3'd0, 16'h0, 12'h0, 1'b0, 1'b1);
        chk("R4", log_q, w);
        chk_all("R4", "R4");

        // R5: ue on 3 and 1 and ce on 0 -> uncorrectable quadword 1
        step(4'b0001, 4'b1010, 32'h4433_2211, 2'd1, 3'd2, 16'h1234, 12'h567, 1'b0, 1'b0);
        chk("R5", log_q, {8'h22, 1'b1, 2'd1, 2'd1, 3'd2, 16'h1234, 12'h567, 20'h0});
        chk_all("R5", "R7");

        // R8: clear both with a new correctable error on quadword 3
        step(4'b1000, 4'b0000, 32'h9900_0000, 2'd2, 3'd7, 16'hFFFF, 12'hFFF, 1'b1, 1'b1);
        chk("R8", log_q, {8'h99, 1'b0, 2'd3, 2'd2, 3'd7, 16'hFFFF, 12'hFFF, 20'h0});
        chk_all("R8", "R8");

        // R9: ue arrives while only ce set
        w = log_q;
        step(4'b0000, 4'b0100, 32'h00AA_0000, 2'd1, 3'd1, 16'h0F0F, 12'h0F0, 1'b0, 1'b0);
        chk("R9", log_q, w);
        chk("R9", {63'h0, ue_flag}, 64'h1);
        chk_all("R9", "R9");
        step(4'b0000, 4'b0000, 32'h0, 2'd0, 3'd0, 16'h0, 12'h0, 1'b1, 1'b1);
        chk_all("R4", "R4");
        idle();
        chk_all("R4", "R4");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] ce, ue;
            ce = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            ue = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            step(ce, ue, $urandom, 2'($urandom), 3'($urandom), 16'($urandom),
                 12'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0);
            chk_all("R5", "R7");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule